// File: doc/BRIEF.md
# SPI Controller with Held Chip-Select

This block is a single-channel SPI controller. It moves one word at a time between a transmit data register and a receive data register. Each word can be transmit-and-receive, transmit-only or receive-only. A word starts by itself when the data registers are ready for the selected mode. Software builds a longer transaction by leaving chip-select asserted across several words. Each of those words may use a different mode and a different length.

Chip-select follows the channel enable. A force control can hold it active after the enable is cleared, but only while the single-channel bit is set. Mode, word length and clock divider are taken at the start of each word. Clock polarity, clock phase and chip-select polarity are taken only while chip-select is inactive. A reconfiguration made between words therefore never disturbs a word already on the wire.

Top module: `spi_hold_ctrl`

## Requirements
- R1: Reset state: chip-select at its inactive level (high, since the reset polarity is active-low), SCLK at 0, TX-empty flag 1, RX-full flag 0, end-of-transfer flag 0.
- R2: While the enable is 1, chip-select sits at the active level: low when `cfg_cs_pol` is 0, high when it is 1.
- R3: `cfg_mode` sets the word type: 00 transmit-and-receive, 01 transmit-only, 10 receive-only, 11 acts as transmit-and-receive. A transmit-only word leaves the RX register and RX-full flag unchanged. A receive-only word shifts out zeros and does not consume the TX register.
- R4: A word starts only when it can. Modes that transmit need the TX register loaded (TX-empty 0). Modes that receive need the RX-full flag clear. A word in transmit-and-receive mode therefore waits while RX-full is 1.
- R5: Word length is `cfg_wlen`+1 bits, and values below 3 are treated as 3, so the range is 4 to 32 bits. Data is shifted MSB first. The received word is right-aligned in `rx_rdata`, with the upper bits 0.
- R6: The end-of-transfer flag clears when a word starts and sets when that word completes.
- R7: The RX-full flag sets when a received word is moved into the RX register. A pulse on `rx_rd` clears it.
- R8: The TX-empty flag sets when the TX register is loaded into the shifter. A pulse on `tx_wr` clears it.
- R9: When the enable is 0, a force bit of 1 keeps chip-select active if `cfg_single` is 1. If `cfg_single` is 0, the force bit has no effect.
- R10: After the last word, chip-select returns to its inactive level once the enable is 0 and the force bit is 0.
- R11: Mode, word length and divider changes made during a word do not affect that word.
- R12: Changes to `cfg_cpol`, `cfg_cpha` and `cfg_cs_pol` are ignored while chip-select is active. They take effect once chip-select is inactive.
- R13: SCLK rests at the clock polarity level, and each SCLK half period lasts `cfg_div`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_force | input | 1 | Hold chip-select active between words |
| cfg_single | input | 1 | Single-channel mode; enables the force control |
| cfg_mode | input | 2 | Word type: 00 duplex, 01 TX only, 10 RX only, 11 duplex |
| cfg_cs_pol | input | 1 | Chip-select active level (1 = active high) |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_div | input | 8 | SCLK half period minus one, in system clocks |
| tx_wr | input | 1 | Write strobe for the TX data register |
| tx_wdata | input | 32 | TX data |
| rx_rd | input | 1 | Read strobe for the RX data register |
| rx_rdata | output | 32 | RX data register |
| st_tx_empty | output | 1 | TX register empty |
| st_rx_full | output | 1 | RX register holds an unread word |
| st_eot | output | 1 | Last word has completed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip-select |

## Verification
A fault in the start gating shows up at the end-of-transfer flag. Either the flag never falls, or it falls while RX-full or TX-empty says it should not, within one system clock of the gating condition. A fault in the shift or length state shows up as a wrong word. The target model sees it on MOSI at the final SCLK edge, and the RX register shows it on the same cycle the end-of-transfer flag rises. A fault in the latched polarity or the chip-select hold state shows up on `cs_out` or on the idle SCLK level one clock after the control input changes.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    XFER_DUPLEX  = 2'b00,
    XFER_TX_ONLY = 2'b01,
    XFER_RX_ONLY = 2'b10,
    XFER_ALT     = 2'b11
  } xfer_mode_e;

  // word puts TX register data on the wire
  function automatic logic mode_sends(input xfer_mode_e m);
    return m != XFER_RX_ONLY;
  endfunction

  // word stores its received bits into the RX register
  function automatic logic mode_receives(input xfer_mode_e m);
    return m != XFER_TX_ONLY;
  endfunction

endpackage

// File: rtl/spi_hold_clkgen.sv
module spi_hold_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R13: with a divider above zero, SCLK edges are never on adjacent clocks
  assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_in != '0) |=> !tick);

endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                cpha,
  input  logic                tick,
  input  logic                miso,
  output logic                mosi,
  output logic                phase,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);

  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-1:0] rx_sh;
  logic [LEN_W:0]      edge_cnt;
  logic [LEN_W-1:0]    len_q;
  logic                active;
  logic                mosi_q;
  logic                ph;

  logic leading, sample_ev, drive_ev, last_edge;

  assign leading   = ~edge_cnt[0];
  assign sample_ev = leading ^ cpha;
  assign drive_ev  = ~sample_ev;
  assign last_edge = (edge_cnt == {len_q, 1'b1});
  assign done      = active && tick && last_edge;
  assign mosi      = mosi_q;
  assign phase     = ph;
  // with trailing-edge sampling the last bit arrives on the final edge
  assign rx_word   = cpha ? {rx_sh[MAX_BITS-2:0], miso} : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_cnt <= '0;
      len_q    <= '0;
      active   <= 1'b0;
      mosi_q   <= 1'b0;
      ph       <= 1'b0;
    end else if (load) begin
      len_q    <= len_m1;
      edge_cnt <= '0;
      active   <= 1'b1;
      ph       <= 1'b0;
      rx_sh    <= '0;
      if (cpha) begin
        tx_sh  <= tx_word;
        mosi_q <= 1'b0;
      end else begin
        tx_sh  <= tx_word << 1;
        mosi_q <= tx_word[len_m1];
      end
    end else if (active && tick) begin
      ph       <= ~ph;
      edge_cnt <= edge_cnt + 1'b1;
      if (sample_ev) begin
        rx_sh <= {rx_sh[MAX_BITS-2:0], miso};
      end
      if (drive_ev && !last_edge) begin
        mosi_q <= tx_sh[len_q];
        tx_sh  <= tx_sh << 1;
      end
      if (last_edge) begin
        active <= 1'b0;
      end
    end
  end

  // R11: the word length captured at the start holds for the whole word
  assert_len_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(len_q));

  // R13: between words the clock phase is back at its idle value
  assert_sclk_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ph);

endmodule

// File: rtl/spi_hold_csctl.sv
module spi_hold_csctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic force_bit,
  input  logic single,
  input  logic busy,
  input  logic cfg_cs_pol,
  input  logic cfg_cpol,
  input  logic cfg_cpha,
  output logic cs_act,
  output logic cs_pol_q,
  output logic cpol_q,
  output logic cpha_q
);

  logic cs_nxt;
  logic hold_req;

  assign hold_req = single && force_bit;
  assign cs_nxt   = en || busy || hold_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act   <= 1'b0;
      cs_pol_q <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
    end else begin
      cs_act <= cs_nxt;
      if (!cs_nxt) begin
        cs_pol_q <= cfg_cs_pol;
        cpol_q   <= cfg_cpol;
        cpha_q   <= cfg_cpha;
      end
    end
  end

  // R12: the latched polarities do not move while chip-select is active
  assert_pol_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> $stable({cs_pol_q, cpol_q, cpha_q}));

  // R9: without single-channel mode, force cannot hold chip-select
  assert_force_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy && !single) |=> !cs_act);

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  localparam int LEN_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_force,
  input  logic                cfg_single,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_cs_pol,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic [LEN_W-1:0]    cfg_wlen,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                tx_wr,
  input  logic [MAX_BITS-1:0] tx_wdata,
  input  logic                rx_rd,
  output logic [MAX_BITS-1:0] rx_rdata,
  output logic                st_tx_empty,
  output logic                st_rx_full,
  output logic                st_eot,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_out
);

  localparam logic [LEN_W-1:0] MIN_LEN_M1 = LEN_W'(MIN_BITS - 1);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    return (raw < MIN_LEN_M1) ? MIN_LEN_M1 : raw;
  endfunction

  xfer_mode_e          cur_mode, mode_q;
  logic [DIV_W-1:0]    div_q;
  logic [MAX_BITS-1:0] tx_data_q, rx_data_q, rx_word, shift_in;
  logic                tx_empty_q, rx_full_q, eot_q, busy;
  logic                cs_act, cs_pol_q, cpol_q, cpha_q;
  logic                tick, word_done, sclk_ph;
  logic                ready, word_start, tx_load, rx_store;

  assign cur_mode   = xfer_mode_e'(cfg_mode);
  assign ready      = (!mode_sends(cur_mode) || !tx_empty_q) &&
                      (!mode_receives(cur_mode) || !rx_full_q);
  assign word_start = !busy && cfg_en && cs_act && ready;
  assign tx_load    = word_start && mode_sends(cur_mode);
  assign rx_store   = word_done && mode_receives(mode_q);
  assign shift_in   = mode_sends(cur_mode) ? tx_data_q : '0;

  spi_hold_csctl i_csctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .force_bit (cfg_force),
    .single    (cfg_single),
    .busy      (busy),
    .cfg_cs_pol(cfg_cs_pol),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cs_act    (cs_act),
    .cs_pol_q  (cs_pol_q),
    .cpol_q    (cpol_q),
    .cpha_q    (cpha_q)
  );

  spi_hold_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div_in(div_q),
    .tick  (tick)
  );

  spi_hold_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) i_shifter (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (word_start),
    .tx_word(shift_in),
    .len_m1 (clamp_len(cfg_wlen)),
    .cpha   (cpha_q),
    .tick   (tick),
    .miso   (miso),
    .mosi   (mosi),
    .phase  (sclk_ph),
    .done   (word_done),
    .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= XFER_DUPLEX;
      div_q  <= '0;
      eot_q  <= 1'b0;
    end else if (word_start) begin
      busy   <= 1'b1;
      mode_q <= cur_mode;
      div_q  <= cfg_div;
      eot_q  <= 1'b0;
    end else if (word_done) begin
      busy   <= 1'b0;
      eot_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data_q  <= '0;
      tx_empty_q <= 1'b1;
    end else if (tx_wr) begin
      tx_data_q  <= tx_wdata;
      tx_empty_q <= 1'b0;
    end else if (tx_load) begin
      tx_empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
    end else if (rx_store) begin
      rx_data_q <= rx_word;
      rx_full_q <= 1'b1;
    end else if (rx_rd) begin
      rx_full_q <= 1'b0;
    end
  end

  assign rx_rdata    = rx_data_q;
  assign st_tx_empty = tx_empty_q;
  assign st_rx_full  = rx_full_q;
  assign st_eot      = eot_q;
  assign sclk        = cpol_q ^ sclk_ph;
  assign cs_out      = cs_act ? cs_pol_q : ~cs_pol_q;

  // R6: a started word drops the end-of-transfer flag
  assert_eot_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> !st_eot);

  // R7: storing a received word raises the full flag
  assert_rx_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store |=> st_rx_full);

  // R8: loading the shifter without a new write empties the TX register
  assert_tx_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_wr) |=> st_tx_empty);

  // R2: chip-select is active for the whole of every word
  assert_cs_held_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cs_act);

  // R3: a transmit-only word leaves the RX register alone
  assert_txonly_rx_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_receives(mode_q)) |=> $stable(rx_data_q));

endmodule

// File: tb/test_spi_hold_ctrl.sv
`timescale 1ns/1ps
module test_spi_hold_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 0, cfg_force = 0, cfg_single = 0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_cs_pol = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [4:0]  cfg_wlen = 5'd7;
  logic [7:0]  cfg_div = 8'd1;
  logic        tx_wr = 0, rx_rd = 0;
  logic [31:0] tx_wdata = '0;
  logic [31:0] rx_rdata;
  logic        st_tx_empty, st_rx_full, st_eot, sclk, mosi, cs_out;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  // target model state
  logic        p_cpol = 0, p_cpha = 0, p_cspol = 0;
  int          p_wl = 8;
  int          p_cnt = 0;
  logic [31:0] p_reply = '0;
  logic [31:0] p_got = '0;
  logic [31:0] exp_mosi_q[$];

  always #2.5 clk = ~clk;

  spi_hold_ctrl i_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_force(cfg_force),
    .cfg_single(cfg_single), .cfg_mode(cfg_mode), .cfg_cs_pol(cfg_cs_pol),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wlen(cfg_wlen),
    .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .st_eot(st_eot), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int bits);
    return (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  // monitor: target side compares every completed word against the queue
  task automatic word_end();
    logic [31:0] e;
    if (exp_mosi_q.size() == 0) begin
      chk(1'b0, "R5 unexpected word on MOSI", p_got, 32'h0);
    end else begin
      e = exp_mosi_q.pop_front();
      chk(((p_got ^ e) & wmask(p_wl)) == 0, "R5 R11 MOSI word MSB first",
          p_got & wmask(p_wl), e & wmask(p_wl));
    end
    p_cnt = 0;
    p_got = '0;
  endtask

  always @(sclk) begin
    bit lead;
    #1;
    if (rst_n && cs_out == p_cspol) begin
      lead = (sclk != p_cpol);
      if (lead ^ p_cpha) begin
        p_got = {p_got[30:0], mosi};
        p_cnt++;
        if (p_cpha && p_cnt == p_wl) word_end();
      end else begin
        if (!p_cpha && p_cnt == p_wl) word_end();
        else if (p_cnt < p_wl) miso = p_reply[p_wl-1-p_cnt];
      end
    end
  end

  // driver: push the expected MOSI word and arm the target reply
  task automatic prep(input int bits, input logic [31:0] mo, input logic [31:0] reply);
    p_wl = bits;
    p_reply = reply;
    p_cnt = 0;
    p_got = '0;
    exp_mosi_q.push_back(mo);
    if (!p_cpha) miso = reply[bits-1];
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_write(input logic [31:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(st_rx_full == 1'b0, "R7 read clears RX-full", st_rx_full, 1'b0);
  endtask

  task automatic wait_word(input string tag);
    int n = 0;
    while (st_eot && n < 3000) begin @(negedge clk); n++; end
    chk(!st_eot, {"R6 eot clears at start ", tag}, st_eot, 1'b0);
    while (!st_eot && n < 3000) begin @(negedge clk); n++; end
    chk(st_eot, {"R6 eot sets at end ", tag}, st_eot, 1'b1);
    chk(exp_mosi_q.size() == 0, {"R5 word seen by target ", tag}, exp_mosi_q.size(), 0);
  endtask

  task automatic half_period(output int n);
    logic s0, s1;
    int guard = 0;
    s0 = sclk;
    while (sclk == s0 && guard < 500) begin @(negedge clk); guard++; end
    s1 = sclk;
    n = 0;
    do begin @(negedge clk); n++; end while (sclk == s1 && n < 500);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hp;
    cycles(3);
    chk(cs_out == 1'b1, "R1 reset chip-select inactive", cs_out, 1'b1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 1'b0);
    chk(st_tx_empty == 1'b1, "R1 reset TX-empty", st_tx_empty, 1'b1);
    chk(st_rx_full == 1'b0, "R1 reset RX-full", st_rx_full, 1'b0);
    chk(st_eot == 1'b0, "R1 reset eot", st_eot, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // enable with force in single mode, nothing to send yet
    cycles(1); cfg_single = 1; cfg_force = 1; cfg_en = 1;
    cycles(2);
    chk(cs_out == 1'b0, "R2 chip-select active low", cs_out, 1'b0);
    cycles(20);
    chk(st_eot == 1'b0, "R4 no word without TX data", st_eot, 1'b0);
    chk(sclk == 1'b0, "R4 R13 sclk idle while waiting", sclk, 1'b0);

    // W1 duplex 8 bits
    prep(8, 32'hA5, 32'h3C);
    tx_write(32'hA5);
    wait_word("W1");
    chk(st_tx_empty == 1'b1, "R8 TX-empty after load", st_tx_empty, 1'b1);
    chk(st_rx_full == 1'b1, "R7 RX-full after word", st_rx_full, 1'b1);
    chk(rx_rdata == 32'h3C, "R5 RX word W1", rx_rdata, 32'h3C);

    // W2 blocked by RX-full
    prep(8, 32'h5A, 32'hC3);
    tx_write(32'h5A);
    cycles(40);
    chk(st_eot == 1'b1, "R4 duplex waits on RX-full", st_eot, 1'b1);
    chk(st_tx_empty == 1'b0, "R8 write clears TX-empty", st_tx_empty, 1'b0);
    chk(cs_out == 1'b0, "R2 chip-select held between words", cs_out, 1'b0);
    rx_read();
    wait_word("W2");
    chk(rx_rdata == 32'hC3, "R5 RX word W2", rx_rdata, 32'hC3);
    rx_read();

    // W3 transmit-only 12 bits
    cfg_mode = 2'b01; cfg_wlen = 5'd11;
    prep(12, 32'hABC, 32'hFFF);
    tx_write(32'hABC);
    wait_word("W3");
    chk(st_rx_full == 1'b0, "R3 TX-only leaves RX-full", st_rx_full, 1'b0);
    chk(rx_rdata == 32'hC3, "R3 TX-only leaves RX data", rx_rdata, 32'hC3);

    // W4 receive-only 16 bits, starts as soon as the mode is set
    prep(16, 32'h0, 32'hBEEF);
    @(negedge clk); cfg_mode = 2'b10; cfg_wlen = 5'd15;
    wait_word("W4");
    chk(rx_rdata == 32'hBEEF, "R3 RX-only word", rx_rdata, 32'hBEEF);
    tx_write(32'h77);
    cycles(40);
    chk(st_tx_empty == 1'b0, "R3 RX-only keeps TX data", st_tx_empty, 1'b0);
    chk(st_eot == 1'b1, "R4 RX-only waits on RX-full", st_eot, 1'b1);

    // W5 transmit-only 8 bits sends the retained TX data
    prep(8, 32'h77, 32'h0);
    @(negedge clk); cfg_mode = 2'b01; cfg_wlen = 5'd7;
    wait_word("W5");
    chk(rx_rdata == 32'hBEEF, "R3 TX-only keeps RX data", rx_rdata, 32'hBEEF);
    rx_read();

    // W6 duplex 32 bits, configuration changed mid-word
    @(negedge clk); cfg_mode = 2'b00; cfg_wlen = 5'd31; cfg_div = 8'd2;
    prep(32, 32'hDEADBEEF, 32'h12345678);
    tx_write(32'hDEADBEEF);
    cycles(10);
    cfg_wlen = 5'd7; cfg_div = 8'd0; cfg_mode = 2'b01;
    half_period(hp);
    chk(hp == 3, "R13 R11 half period uses start divider", hp, 3);
    wait_word("W6");
    chk(rx_rdata == 32'h12345678, "R11 full-length RX word", rx_rdata, 32'h12345678);
    rx_read();

    // polarity changes while active are held back
    @(negedge clk); cfg_cpol = 1;
    cycles(5);
    chk(sclk == 1'b0, "R12 cpol ignored while active", sclk, 1'b0);
    cfg_cs_pol = 1;
    cycles(5);
    chk(cs_out == 1'b0, "R12 cs polarity ignored while active", cs_out, 1'b0);
    cfg_cs_pol = 0;
    cfg_en = 0;
    cycles(5);
    chk(cs_out == 1'b0, "R9 force holds chip-select", cs_out, 1'b0);
    cfg_single = 0;
    cycles(2);
    chk(cs_out == 1'b1, "R9 force ignored without single mode", cs_out, 1'b1);
    chk(sclk == 1'b1, "R12 R13 new cpol applied when inactive", sclk, 1'b1);
    cfg_single = 1;
    cycles(2);
    chk(cs_out == 1'b0, "R9 force with single mode", cs_out, 1'b0);
    cfg_force = 0;
    cycles(2);
    chk(cs_out == 1'b1, "R10 chip-select released", cs_out, 1'b1);

    // active-high chip-select, mode 3 timing
    cfg_cpha = 1; cfg_cs_pol = 1;
    cycles(2);
    chk(cs_out == 1'b0, "R12 active-high inactive level", cs_out, 1'b0);
    p_cpol = 1; p_cpha = 1; p_cspol = 1;
    cfg_mode = 2'b00; cfg_wlen = 5'd5;
    cfg_en = 1;
    cycles(2);
    chk(cs_out == 1'b1, "R2 chip-select active high", cs_out, 1'b1);
    prep(6, 32'h2D, 32'h15);
    tx_write(32'h2D);
    wait_word("W7");
    chk(rx_rdata == 32'h15, "R5 trailing-edge RX word", rx_rdata, 32'h15);
    rx_read();

    // W8 mode 11 with a too-short length clamped to 4 bits
    @(negedge clk); cfg_mode = 2'b11; cfg_wlen = 5'd1;
    prep(4, 32'hB, 32'h6);
    tx_write(32'hB);
    wait_word("W8");
    chk(rx_rdata == 32'h6, "R5 R3 clamped 4-bit duplex word", rx_rdata, 32'h6);
    chk(sclk == 1'b1, "R13 idle level after word", sclk, 1'b1);
    rx_read();
    cfg_en = 0;
    cycles(2);
    chk(cs_out == 1'b0, "R10 active-high chip-select released", cs_out, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule